// File: doc/BRIEF.md
# Pseudo-static RAM asynchronous page-read sequencer

This block is a host-side controller that reads a run of consecutive words from a pseudo-static RAM over its asynchronous interface, using page mode. A request carries a start word address and a word count and is taken on a valid/ready handshake. The block drives chip enable, address valid, output enable, both byte enables and the address bus. It waits out an access time counted in controller clock cycles, samples the data bus and returns each word as a one-cycle pulse on a valid/data stream.

The first word after chip enable falls costs a long access time. Later words in the same 16-word page are reached by changing only address bits [3:0], and each costs a shorter access time. Chip enable is released for one cycle, followed by a fresh long access, in two cases: when the next word starts a new 16-word page, and when one more in-page access would push the chip-enable low time past its limit. When the memory is wired with its low address lines shared with the data pins, page mode is not available. In that configuration the block refuses any request for more than one word.

Top module: `psram_page_rd`

## Requirements
- R1: After reset, ce_no, oe_no, adv_no, ub_no and lb_no are high, rd_valid_o and rej_o are low, and cmd_ready_o is high.
- R2: An accepted request of length N (1 to 255) returns exactly N words on rd_valid_o/rd_data_o. Word i is the value on data_i while addr_o holds start+i.
- R3: The first word of each chip-enable low period is sampled after FIRST_CYC cycles of chip enable low with the address stable. The first word of a request appears on rd_valid_o exactly FIRST_CYC clock edges after the accepting edge. Every later word in the same period is sampled after PAGE_CYC cycles of a stable address.
- R4: While chip enable stays low, addr_o bits above bit 3 do not change. Reading across a 16-word boundary releases chip enable for at least one cycle.
- R5: No chip-enable low period lasts more than CE_MAX_CYC cycles. A new period starts only at a page boundary or when one more in-page access would exceed that limit.
- R6: Whenever chip enable is low, address valid and both byte enables are low. Output enable is low exactly while chip enable is low.
- R7: With mux_mode_i high, a request of more than one word is refused: rej_o pulses high for one cycle, chip enable stays high and no word is returned. A one-word request in that mode is served normally.
- R8: A request of length zero is refused in the same way as in R7.
- R9: wait_i has no effect on any output.
- R10: cmd_ready_o is low from acceptance until the last word of the request has been sampled, and high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Read request present |
| cmd_ready_o | output | 1 | Request can be taken |
| cmd_addr_i | input | ADDR_W | Start word address |
| cmd_len_i | input | LEN_W | Word count |
| mux_mode_i | input | 1 | Memory wired with address and data sharing pins; page mode refused |
| rej_o | output | 1 | One-cycle pulse: request refused |
| ce_no | output | 1 | Chip enable, active low |
| adv_no | output | 1 | Address valid, active low |
| oe_no | output | 1 | Output enable, active low |
| ub_no | output | 1 | Upper byte enable, active low |
| lb_no | output | 1 | Lower byte enable, active low |
| addr_o | output | ADDR_W | Word address to the memory |
| data_i | input | DATA_W | Data bus from the memory |
| wait_i | input | 1 | Memory wait signal, unused in asynchronous reads |
| rd_valid_o | output | 1 | Returned word valid |
| rd_data_o | output | DATA_W | Returned word |

## Verification
The assertions assume that the parameters satisfy CE_MAX_CYC >= FIRST_CYC + PAGE_CYC and that reset is applied before the first request. They also assume that a request does not run past the top of the address space, so addr_o only increments within a request. The stimulus keeps every start address plus length far below the address limit and changes requests only on the falling clock edge. The bench's memory model returns a poison word whenever data is sampled before the access time it owes, or while any strobe is wrong. Correct data therefore also shows that the timing was correct.

// File: rtl/psram_page_pkg.sv
package psram_page_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PAGE  = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/psram_acc_timer.sv
module psram_acc_timer #(
  parameter int FIRST_CYC = 6,
  parameter int PAGE_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_first_i,
  input  logic load_page_i,
  output logic done_o
);
  localparam int MAXC = (FIRST_CYC > PAGE_CYC) ? FIRST_CYC : PAGE_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_first_i)  cnt_q <= TW'(FIRST_CYC - 1);
    else if (load_page_i)   cnt_q <= TW'(PAGE_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/psram_ce_budget.sv
module psram_ce_budget #(
  parameter int PAGE_CYC   = 2,
  parameter int CE_MAX_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seg_start_i,
  input  logic ce_low_i,
  output logic room_o
);
  localparam int BW = $clog2(CE_MAX_CYC + PAGE_CYC + 1);

  logic [BW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_q <= '0;
    else if (seg_start_i) low_q <= BW'(1);
    else if (ce_low_i)    low_q <= low_q + 1'b1;
  end

  // room for one more in-page access inside this low period
  assign room_o = (low_q + BW'(PAGE_CYC)) <= BW'(CE_MAX_CYC);

  // R5
  ce_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_low_i |-> (low_q <= BW'(CE_MAX_CYC)));
endmodule

// File: rtl/psram_page_rd.sv
module psram_page_rd
  import psram_page_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 8,
  parameter int FIRST_CYC  = 6,
  parameter int PAGE_CYC   = 2,
  parameter int CE_MAX_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              mux_mode_i,
  output logic              rej_o,
  output logic              ce_no,
  output logic              adv_no,
  output logic              oe_no,
  output logic              ub_no,
  output logic              lb_no,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wait_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PG_BITS = 4;

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              rej_q, vld_q;
  logic [DATA_W-1:0] dat_q;
  logic              accept, bad_req, in_acc, t_done, room;
  logic              capture, last_word, page_end, load_first, load_page;
  logic              wait_unused;

  assign wait_unused = wait_i;

  assign accept     = cmd_valid_i && (state_q == ST_IDLE);
  assign bad_req    = (cmd_len_i == '0) || (mux_mode_i && (cmd_len_i != LEN_W'(1)));
  assign in_acc     = (state_q == ST_FIRST) || (state_q == ST_PAGE);
  assign capture    = in_acc && t_done;
  assign last_word  = (rem_q == LEN_W'(1));
  assign page_end   = (addr_q[PG_BITS-1:0] == '1);
  assign load_first = (accept && !bad_req) || (state_q == ST_GAP);
  assign load_page  = capture && !last_word && !page_end && room;

  psram_acc_timer #(
    .FIRST_CYC(FIRST_CYC),
    .PAGE_CYC (PAGE_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_first_i(load_first),
    .load_page_i (load_page),
    .done_o      (t_done)
  );

  psram_ce_budget #(
    .PAGE_CYC  (PAGE_CYC),
    .CE_MAX_CYC(CE_MAX_CYC)
  ) u_budget (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_start_i(load_first),
    .ce_low_i   (in_acc),
    .room_o     (room)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      rej_q   <= 1'b0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
    end else begin
      rej_q <= accept && bad_req;
      vld_q <= capture;
      if (capture) dat_q <= data_i;
      unique case (state_q)
        ST_IDLE: if (accept && !bad_req) begin
          addr_q  <= cmd_addr_i;
          rem_q   <= cmd_len_i;
          state_q <= ST_FIRST;
        end
        ST_FIRST, ST_PAGE: if (capture) begin
          if (last_word) begin
            state_q <= ST_IDLE;
          end else begin
            rem_q   <= rem_q - 1'b1;
            addr_q  <= addr_q + 1'b1;
            state_q <= load_page ? ST_PAGE : ST_GAP;
          end
        end
        ST_GAP: state_q <= ST_FIRST;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign ce_no       = !in_acc;
  assign oe_no       = !in_acc;
  assign adv_no      = !in_acc;
  assign ub_no       = !in_acc;
  assign lb_no       = !in_acc;
  assign addr_o      = addr_q;
  assign rej_o       = rej_q;
  assign rd_valid_o  = vld_q;
  assign rd_data_o   = dat_q;

  // R4
  page_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && $past(!ce_no)) |-> (addr_o[ADDR_W-1:PG_BITS] == $past(addr_o[ADDR_W-1:PG_BITS])));
  // R6
  strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |-> (!adv_no && !ub_no && !lb_no && !oe_no));
  // R7
  rej_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> (ce_no && !rd_valid_o));
  // R7
  rej_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |=> !rej_o);
  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> ce_no);
  // R3
  data_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!ce_no));
endmodule

// File: tb/sim_psram_page_rd.sv
module sim_psram_page_rd;
  localparam int ADDR_W = 23, DATA_W = 16, LEN_W = 8;
  localparam int F = 5, P = 2, CEMAX = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, mux_mode = 1'b0, wait_s = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic cmd_ready, rej, ce_n, adv_n, oe_n, ub_n, lb_n, rd_valid;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data_in, rd_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  psram_page_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .FIRST_CYC(F), .PAGE_CYC(P), .CE_MAX_CYC(CEMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .mux_mode_i(mux_mode), .rej_o(rej),
    .ce_no(ce_n), .adv_no(adv_n), .oe_no(oe_n), .ub_no(ub_n), .lb_no(lb_n),
    .addr_o(addr), .data_i(data_in), .wait_i(wait_s),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data));

  function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // memory model: poison word if sampled early or with bad strobes
  logic [ADDR_W-1:0] prev_addr = '0;
  logic prev_ce_n = 1'b1, first_q = 1'b1;
  int age_q = 0, cur_age, need;
  logic is_first;
  always_comb begin
    cur_age  = prev_ce_n ? 1 : ((addr == prev_addr) ? age_q + 1 : 1);
    is_first = prev_ce_n ? 1'b1 : ((addr == prev_addr) ? first_q : 1'b0);
    need     = is_first ? F : P;
    data_in  = (!ce_n && !oe_n && !adv_n && !ub_n && !lb_n && cur_age >= need)
               ? word_of(addr) : 16'hBAD0;
  end
  always @(posedge clk) begin
    cyc       <= cyc + 1;
    prev_addr <= addr;
    prev_ce_n <= ce_n;
    age_q     <= ce_n ? 0 : cur_age;
    first_q   <= is_first;
  end

  // monitors
  logic [DATA_W-1:0] rx [0:255];
  int rx_n = 0, rej_n = 0, falls = 0, run = 0, max_run = 0, sig_err = 0, first_cyc = -1;
  logic last_ce_n = 1'b1;
  logic [ADDR_W-1:0] seg_addr = '0;
  int seg_err = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rx_n < 256) rx[rx_n] = rd_data;
      if (rx_n == 0) first_cyc = cyc;
      rx_n++;
    end
    if (rej) rej_n++;
    if (!ce_n) begin
      if (last_ce_n) begin falls++; run = 0; seg_addr = addr; end
      run++;
      if (run > max_run) max_run = run;
      if (addr[ADDR_W-1:4] != seg_addr[ADDR_W-1:4]) seg_err++;
      if (oe_n || adv_n || ub_n || lb_n) sig_err++;
    end else if (!oe_n) sig_err++;
    last_ce_n = ce_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; rej_n = 0; falls = 0; max_run = 0; sig_err = 0; seg_err = 0; first_cyc = -1;
  endtask

  int acc_cyc;
  task automatic send(input logic [ADDR_W-1:0] a, input int n, input bit mux);
    @(negedge clk);
    cmd_addr = a; cmd_len = LEN_W'(n); mux_mode = mux; cmd_valid = 1'b1;
    @(posedge clk);
    #1 acc_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic int exp_segments(input logic [ADDR_W-1:0] a, input int n);
    int seg = 1, low = F;
    for (int i = 1; i < n; i++) begin
      logic [ADDR_W-1:0] na = a + ADDR_W'(i);
      if (na[3:0] == 4'h0 || low + P > CEMAX) begin seg++; low = F; end
      else low += P;
    end
    return seg;
  endfunction

  task automatic do_read(input logic [ADDR_W-1:0] a, input int n, input string tag);
    int bad = 0;
    clear_mon();
    send(a, n, 1'b0);
    for (int t = 0; t < n * 40 + 50 && rx_n < n; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int i = 0; i < n && i < 256; i++)
      if (rx[i] != word_of(a + ADDR_W'(i))) bad++;
    chk(rx_n == n, {tag, " R2 word count"}, rx_n, n);
    chk(bad == 0, {tag, " R2/R3 data and access time"}, bad, 0);
    chk(first_cyc - acc_cyc == F, {tag, " R3 first-word latency"}, first_cyc - acc_cyc, F);
    chk(max_run <= CEMAX, {tag, " R5 ce low time"}, max_run, CEMAX);
    chk(falls == exp_segments(a, n), {tag, " R4/R5 ce low periods"}, falls, exp_segments(a, n));
    chk(seg_err == 0, {tag, " R4 high address bits"}, seg_err, 0);
    chk(sig_err == 0, {tag, " R6 strobes"}, sig_err, 0);
  endtask

  task automatic t_reset();
    chk(ce_n && oe_n && adv_n && ub_n && lb_n, "R1 strobes high", {ce_n, oe_n, adv_n, ub_n, lb_n}, 5'h1F);
    chk(!rd_valid && !rej, "R1 outputs idle", {rd_valid, rej}, 0);
    chk(cmd_ready, "R1/R10 ready in idle", cmd_ready, 1);
  endtask

  task automatic t_busy();
    clear_mon();
    send(23'h200, 6, 1'b0);
    chk(!cmd_ready, "R10 ready low while busy", cmd_ready, 0);
    for (int t = 0; t < 400 && rx_n < 6; t++) @(negedge clk);
    @(negedge clk);
    chk(cmd_ready, "R10 ready back when done", cmd_ready, 1);
  endtask

  task automatic t_wait_ignored();
    fork
      begin
        for (int t = 0; t < 120; t++) begin @(negedge clk); wait_s = ~wait_s; end
        wait_s = 1'b0;
      end
      do_read(23'h0A7, 9, "R9 wait toggling");
    join
  endtask

  task automatic t_reject(input int n, input bit mux, input string tag);
    clear_mon();
    send(23'h300, n, mux);
    repeat (20) @(negedge clk);
    chk(rej_n == 1, {tag, " one reject pulse"}, rej_n, 1);
    chk(rx_n == 0 && falls == 0, {tag, " no access"}, rx_n + falls, 0);
  endtask

  task automatic t_mux_single();
    int ok;
    clear_mon();
    send(23'h345, 1, 1'b1);
    repeat (F + 6) @(negedge clk);
    ok = (rx_n == 1 && rx[0] == word_of(23'h345) && rej_n == 0) ? 1 : 0;
    chk(ok == 1, "R7 single word in mux mode", rx_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    do_read(23'h100, 4, "in-page");
    do_read(23'h00E, 4, "page cross");
    do_read(23'h040, 16, "full page");
    do_read(23'h003, 40, "long run");
    do_read(23'h7F0, 1, "single");
    t_wait_ignored();
    t_reject(4, 1'b1, "R7 mux page request");
    t_reject(0, 1'b0, "R8 zero length");
    t_mux_single();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule